// File: doc/BRIEF.md
# Transaction Undo-Log Versioning Engine

This block keeps the old and new versions of data apart for a single hardware transaction by writing in place. Once a transaction has been opened, each store first reads the value already held at the target address. It then records that address and the old value in a small internal log, and in the same cycle it writes the new value into the backing memory. The new data is therefore visible at once. Committing a transaction costs nothing beyond forgetting the log. Aborting it replays the log from the newest entry to the oldest, which puts every touched location back to the value it held before the transaction opened.

A command port takes open, commit and abort requests. A store port carries an address and data and has a ready handshake. A one-cycle-latency synchronous memory port connects to the backing storage. The log has a fixed capacity. A store that arrives while the log is full is dropped and raises a sticky overflow flag. A store made while no transaction is open is written straight through and is never logged.

Top module: `txn_undo_log`

## Requirements
- R1: After reset, busy, abort_done, txn_active, log_overflow and mem_en are all low, and st_ready is high.
- R2: A store made inside a transaction reads the target address (mem_en=1, mem_we=0) in the cycle it is accepted. In the following cycle it writes the new data there, so memory holds the new value before any commit.
- R3: The log entry (address and old value) is recorded in the same cycle as the data write. st_ready is low during that cycle.
- R4: Commit (cmd_op=2'b10) closes the transaction and empties the log. No memory access takes place in the cycle the commit is taken, and the stored values remain.
- R5: Abort (cmd_op=2'b11) writes every logged old value back, one entry per cycle, newest first. A location stored several times therefore ends with its value from before the transaction.
- R6: After an abort with N logged entries is accepted, busy stays high and abort_done rises in the (N+1)th cycle. abort_done is high for that single cycle only. Commands presented while busy are ignored.
- R7: A store inside a transaction while the log already holds DEPTH entries is dropped. It causes no memory access and sets log_overflow, which stays set until the next open.
- R8: A store outside a transaction writes memory in its accept cycle without reading or logging, and a later abort does not undo it.
- R9: Open (cmd_op=2'b01) sets txn_active, empties the log and clears log_overflow. 2'b00 is a no-op.
- R10: When cmd_valid and st_valid are both high, the command is taken and st_ready is low, so the store waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 01 open, 10 commit, 11 abort, 00 no-op |
| busy | output | 1 | Engine is in a store write-back or abort replay |
| abort_done | output | 1 | One-cycle pulse at the end of an abort replay |
| txn_active | output | 1 | A transaction is open |
| log_overflow | output | 1 | Sticky: a transactional store was dropped because the log was full |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store is taken on this edge when st_valid is high |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read |

## Verification
A command and a store can reach the engine in the same cycle, and the command must win. The bench raises a commit and a store together. It checks that st_ready stays low in that cycle. It then checks that the store is taken on the next cycle as a direct, unlogged write, because the transaction has closed by then. A second overlap sits inside the abort replay: the bench keeps an open request asserted for the whole replay. It then checks that the engine returns with no transaction open and that the restore writes arrive in newest-first order.

// File: rtl/ulog_pkg.sv
package ulog_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_BEGIN  = 2'b01,
    OP_COMMIT = 2'b10,
    OP_ABORT  = 2'b11
  } ulog_op_e;

  typedef enum logic [1:0] {
    S_IDLE    = 2'b00,
    S_LOGWR   = 2'b01,
    S_RESTORE = 2'b10
  } ulog_state_e;

  // Log has no room for another entry
  function automatic logic ulog_is_full(input int unsigned cnt, input int unsigned depth);
    return cnt >= depth;
  endfunction

  // Slot that a replay step reads: the newest live entry
  function automatic int unsigned ulog_newest(input int unsigned cnt);
    return (cnt == 0) ? 0 : cnt - 1;
  endfunction

endpackage

// File: rtl/ulog_store.sv
module ulog_store #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] top_addr,
  output logic [DW-1:0] top_data
);
  import ulog_pkg::*;

  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign wr_idx = cnt[IW-1:0];
  assign rd_idx = IW'(ulog_newest(int'(cnt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (push) begin
      cnt <= cnt + CW'(1);
    end else if (pop && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) begin
      ent_addr[wr_idx] <= push_addr;
      ent_data[wr_idx] <= push_data;
    end
  end

  assign top_addr = ent_addr[rd_idx];
  assign top_data = ent_data[rd_idx];

endmodule

// File: rtl/ulog_ctrl.sv
module ulog_ctrl #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] top_addr,
  input  logic [DW-1:0] top_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          log_clear,
  output logic          log_push,
  output logic [AW-1:0] log_addr,
  output logic [DW-1:0] log_data,
  output logic          log_pop,
  output logic          busy,
  output logic          st_ready,
  output logic          abort_done,
  output logic          txn_active,
  output logic          log_overflow,
  output logic          ev_commit,
  output logic          ev_reject
);
  import ulog_pkg::*;

  ulog_state_e   state;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic          full;
  logic          cmd_take;
  logic          st_take;
  logic          st_log;
  logic          st_direct;
  logic          is_begin;
  logic          is_abort;

  assign full      = ulog_is_full(int'(cnt), DEPTH);
  assign busy      = (state != S_IDLE);
  assign cmd_take  = cmd_valid && !busy;
  assign st_ready  = !busy && !cmd_valid;
  assign st_take   = st_valid && st_ready;
  assign st_log    = st_take && txn_active && !full;
  assign ev_reject = st_take && txn_active && full;
  assign st_direct = st_take && !txn_active;
  assign is_begin  = cmd_take && (ulog_op_e'(cmd_op) == OP_BEGIN);
  assign ev_commit = cmd_take && (ulog_op_e'(cmd_op) == OP_COMMIT);
  assign is_abort  = cmd_take && (ulog_op_e'(cmd_op) == OP_ABORT);
  assign log_clear = is_begin || ev_commit;
  assign log_addr  = hold_addr;
  assign log_data  = mem_rdata;

  always_comb begin
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = st_addr;
    mem_wdata  = st_data;
    log_push   = 1'b0;
    log_pop    = 1'b0;
    abort_done = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (st_log) begin
          mem_en = 1'b1;
        end else if (st_direct) begin
          mem_en = 1'b1;
          mem_we = 1'b1;
        end
      end
      S_LOGWR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = hold_addr;
        mem_wdata = hold_data;
        log_push  = 1'b1;
      end
      S_RESTORE: begin
        if (cnt != '0) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = top_addr;
          mem_wdata = top_data;
          log_pop   = 1'b1;
        end else begin
          abort_done = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      txn_active   <= 1'b0;
      log_overflow <= 1'b0;
      hold_addr    <= '0;
      hold_data    <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (is_abort)    state <= S_RESTORE;
          else if (st_log) state <= S_LOGWR;
        end
        S_LOGWR:   state <= S_IDLE;
        S_RESTORE: if (cnt == '0) state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
      if (is_begin)                   txn_active <= 1'b1;
      else if (ev_commit || is_abort) txn_active <= 1'b0;
      if (is_begin)       log_overflow <= 1'b0;
      else if (ev_reject) log_overflow <= 1'b1;
      if (st_log) begin
        hold_addr <= st_addr;
        hold_data <= st_data;
      end
    end
  end

endmodule

// File: rtl/txn_undo_log.sv
module txn_undo_log #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  output logic          busy,
  output logic          abort_done,
  output logic          txn_active,
  output logic          log_overflow,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] log_cnt;
  logic [AW-1:0] top_addr;
  logic [DW-1:0] top_data;
  logic          ev_clear;
  logic          ev_push;
  logic          ev_pop;
  logic [AW-1:0] push_addr;
  logic [DW-1:0] push_data;
  logic          ev_commit;
  logic          ev_reject;

  ulog_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .cnt(log_cnt), .top_addr(top_addr), .top_data(top_data),
    .mem_rdata(mem_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .log_clear(ev_clear), .log_push(ev_push), .log_addr(push_addr),
    .log_data(push_data), .log_pop(ev_pop),
    .busy(busy), .st_ready(st_ready), .abort_done(abort_done),
    .txn_active(txn_active), .log_overflow(log_overflow),
    .ev_commit(ev_commit), .ev_reject(ev_reject)
  );

  ulog_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .clear(ev_clear), .push(ev_push),
    .push_addr(push_addr), .push_data(push_data),
    .pop(ev_pop), .cnt(log_cnt),
    .top_addr(top_addr), .top_data(top_data)
  );

endmodule

// File: rtl/ulog_checker.sv
module ulog_checker #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          abort_done,
  input logic          st_ready,
  input logic          cmd_valid,
  input logic          mem_en,
  input logic          mem_we,
  input logic          log_overflow,
  input logic          ev_push,
  input logic          ev_pop,
  input logic          ev_commit,
  input logic          ev_reject,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  assert_push_with_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |-> (mem_en && mem_we && !st_ready));

  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |-> !mem_en);

  assert_reject_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> log_overflow);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

  assert_commit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> !mem_en);

  assert_restore_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> (cnt == $past(cnt) - CW'(1)));

  assert_restore_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |-> (mem_we && busy));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> (!abort_done && !busy));

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> (!busy && !cmd_valid));

endmodule

bind txn_undo_log ulog_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .abort_done(abort_done),
  .st_ready(st_ready), .cmd_valid(cmd_valid), .mem_en(mem_en), .mem_we(mem_we),
  .log_overflow(log_overflow), .ev_push(ev_push), .ev_pop(ev_pop),
  .ev_commit(ev_commit), .ev_reject(ev_reject), .cnt(log_cnt)
);

// File: tb/txn_undo_log_bench.sv
module txn_undo_log_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int NW    = 1 << AW;

  localparam logic [1:0] C_BEGIN  = 2'b01;
  localparam logic [1:0] C_COMMIT = 2'b10;
  localparam logic [1:0] C_ABORT  = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic          busy, abort_done, txn_active, log_overflow;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_undo_log #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_txn_undo_log (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .abort_done(abort_done), .txn_active(txn_active),
    .log_overflow(log_overflow), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // backing memory, one-cycle read latency
  logic [DW-1:0] bmem [NW];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata      <= bmem[mem_addr];
    end
  end

  // reference model
  logic [DW-1:0]      mmem [NW];
  logic [AW+DW-1:0]   mlog [$];
  bit                 m_active;
  logic [AW+DW-1:0]   exp_q [$];
  string              tag_q [$];

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every memory write must match the next expected one
  always begin
    @(negedge clk);
    #2;
    if (rst_n && mem_en && mem_we) begin
      if (exp_q.size() == 0) begin
        chk("R7", {mem_addr, mem_wdata}, 32'hFFFF_FFFF, "unexpected memory write");
      end else begin
        logic [AW+DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {mem_addr, mem_wdata}, e, "memory write addr/data");
      end
    end
  end

  task automatic chk_mem(input string req);
    int bad = 0;
    for (int i = 0; i < NW; i++) if (bmem[i] !== mmem[i]) bad++;
    chk(req, bad, 0, "memory image mismatches");
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int kind;
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = a; st_data = d;
    forever begin
      @(negedge clk);
      if (st_ready) break;
    end
    if (m_active && mlog.size() < DEPTH) begin
      kind = 0;
      mlog.push_back({a, mmem[a]});
      exp_q.push_back({a, d}); tag_q.push_back("R2");
      mmem[a] = d;
    end else if (m_active) begin
      kind = 1;
    end else begin
      kind = 2;
      exp_q.push_back({a, d}); tag_q.push_back("R8");
      mmem[a] = d;
    end
    @(posedge clk); #1;
    st_valid = 1'b0;
    if (kind == 0) begin
      @(negedge clk);
      chk("R3", st_ready, 1'b0, "st_ready during log write");
      @(negedge clk);
      chk("R2", bmem[a], d, "memory updated before commit");
    end else if (kind == 1) begin
      chk("R7", log_overflow, 1'b1, "overflow flag");
      chk("R7", bmem[a], mmem[a], "rejected store left memory");
    end else begin
      chk("R8", bmem[a], d, "direct store written");
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input bit hold);
    int n;
    int cyc;
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    chk("R9", busy, 1'b0, "command accepted while idle");
    n = mlog.size();
    if (op == C_BEGIN) begin
      m_active = 1'b1; mlog.delete();
    end else if (op == C_COMMIT) begin
      m_active = 1'b0; mlog.delete();
    end else begin
      for (int i = n - 1; i >= 0; i--) begin
        logic [AW-1:0] la;
        logic [DW-1:0] ld;
        {la, ld} = mlog[i];
        exp_q.push_back({la, ld}); tag_q.push_back("R5");
        mmem[la] = ld;
      end
      m_active = 1'b0; mlog.delete();
    end
    @(posedge clk); #1;
    if (op == C_ABORT && hold) cmd_op = C_BEGIN;
    else cmd_valid = 1'b0;
    if (op == C_ABORT) begin
      cyc = 0;
      forever begin
        @(negedge clk);
        cyc++;
        if (abort_done || cyc > DEPTH + 4) break;
      end
      chk("R6", cyc, n + 1, "cycles until abort_done");
      chk("R6", busy, 1'b1, "busy in done cycle");
      cmd_valid = 1'b0;
      @(negedge clk);
      chk("R6", {abort_done, busy}, 2'b00, "done pulse width");
      chk("R6", txn_active, 1'b0, "command during replay ignored");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      bmem[i] = DW'(i * 7 + 3);
      mmem[i] = DW'(i * 7 + 3);
    end
    m_active = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {busy, abort_done, txn_active, log_overflow, mem_en}, 5'b0, "reset outputs");
    chk("R1", st_ready, 1'b1, "ready after reset");

    // R8 store with no transaction open
    do_store(4'd1, 8'hA1);

    // R9 open, R2/R3 logged stores, R4 commit
    do_cmd(C_BEGIN, 1'b0);
    chk("R9", txn_active, 1'b1, "open sets active");
    do_store(4'd2, 8'h11);
    do_store(4'd3, 8'h22);
    do_store(4'd2, 8'h33);
    do_cmd(C_COMMIT, 1'b0);
    chk("R4", txn_active, 1'b0, "commit closes");
    chk_mem("R4");

    // R5 abort with repeated address, R6 command held during replay
    do_cmd(C_BEGIN, 1'b0);
    do_store(4'd5, 8'h50);
    do_store(4'd6, 8'h60);
    do_store(4'd5, 8'h55);
    do_store(4'd7, 8'h70);
    do_cmd(C_ABORT, 1'b1);
    chk_mem("R5");
    chk("R5", bmem[5], DW'(5 * 7 + 3), "oldest value restored");

    // R7 overflow, then abort, then R9 open clears
    do_cmd(C_BEGIN, 1'b0);
    do_store(4'd8, 8'h81);
    do_store(4'd9, 8'h91);
    do_store(4'd10, 8'hA2);
    do_store(4'd8, 8'h82);
    do_store(4'd11, 8'hB3);
    do_store(4'd12, 8'hC4);
    chk("R7", log_overflow, 1'b1, "overflow remains set");
    do_cmd(C_ABORT, 1'b0);
    chk_mem("R5");
    do_cmd(C_BEGIN, 1'b0);
    chk("R9", log_overflow, 1'b0, "open clears overflow");
    do_store(4'd13, 8'hD5);
    do_cmd(C_COMMIT, 1'b0);
    chk_mem("R4");

    // R10 commit and store in the same cycle
    do_cmd(C_BEGIN, 1'b0);
    do_store(4'd14, 8'hE6);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = C_COMMIT;
    st_valid = 1'b1; st_addr = 4'd15; st_data = 8'hF7;
    @(negedge clk);
    chk("R10", st_ready, 1'b0, "store held behind command");
    m_active = 1'b0; mlog.delete();
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R10", st_ready, 1'b1, "store taken next cycle");
    exp_q.push_back({4'd15, 8'hF7}); tag_q.push_back("R10");
    mmem[15] = 8'hF7;
    @(posedge clk); #1;
    st_valid = 1'b0;
    @(negedge clk);
    chk("R10", bmem[15], 8'hF7, "store written directly after commit");

    // R8 direct store survives an abort
    do_store(4'd0, 8'h0F);
    do_cmd(C_ABORT, 1'b0);
    chk("R8", bmem[0], 8'h0F, "direct store not undone");
    chk_mem("R8");

    repeat (3) @(negedge clk);
    chk("R5", exp_q.size(), 0, "all expected writes observed");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule